// File: doc/BRIEF.md
# SCSI Initiator Bus Control Register

This block is the host-visible control and status byte an initiator uses to work the SCSI bus control lines by hand. Software writes the byte to drive reset, busy, select, acknowledge, attention and the data-bus enable. It reads the same byte back, together with two status flags from the arbitration logic. All bus outputs are active-high enables meant for open-drain drivers outside the block.

Arbitration runs by itself once a separate mode register raises `arb_en`. The block watches the synchronised BSY and SEL lines for a stretch of idle cycles. It then drives BSY together with the supplied ID byte and flags arbitration in progress. If another device raises SEL while the block is still contending, the block flags the loss and stops driving. Writing the bus-reset bit raises a latched interrupt and emits a one-cycle internal soft-reset pulse. It also wipes every other piece of state except that bit and the interrupt latch.

The host port is a plain register strobe, not a stream. A write takes effect on the clock edge where `wr_en` is high. `rd_data` always shows the current register contents, so there is no back-pressure.

Top module: `scsi_init_ctl`

## Requirements
- R1: After chip reset, `rd_data` is 0, every bus drive output is low, and `irq` and `soft_rst` are low.
- R2: The register byte is laid out from bit 7 down to bit 0 as: bus reset, arbitration in progress, lost arbitration, ACK, BSY, SEL, ATN, data-bus enable. A write with bit 7 = 1 raises `rst_drv` from the next cycle. `rst_drv` stays high until a write with bit 7 = 0 or a chip reset.
- R3: A write with bit 7 = 1 clears bits 4..0 and both arbitration flags, whatever the written low bits are. It pulses `soft_rst` high for exactly the following cycle. While bit 7 stays set, bits 6..0 read 0.
- R4: A write with bit 7 = 1 sets `irq`. `irq` then holds until `irq_ack` is high on a clock edge. A write to bit 7 never clears it.
- R5: Bits 4..0 (ACK, BSY, SEL, ATN, data-bus enable) are stored from a write, read back unchanged, and drive `ack_drv`, `bsy_drv`, `sel_drv`, `atn_drv` and `db_drv_en`.
- R6: `ack_drv` is low whenever `tgt_mode` is 1. The stored ACK bit still reads back as written.
- R7: The bus counts as free only once the two-flop-synchronised BSY and SEL have both been low for FREE_CYCLES consecutive cycles. With FREE_CYCLES = 4, arbitration in progress appears on the 7th clock edge after both raw lines fall, with `arb_en` already high.
- R8: With `arb_en` high and the bus free, bit 6 sets, `bsy_drv` and `db_drv_en` rise, and `db_out` carries `out_data`. Without `arb_en`, bit 6 never sets.
- R9: During arbitration, SEL seen on the bus while the stored SEL bit is 0 sets bit 5. Bit 6 stays set. `bsy_drv` and `db_drv_en` then follow only the stored bits.
- R10: Clearing `arb_en` clears bits 6 and 5 on the next edge.
- R11: Host writes to bits 6 and 5 have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Current register byte |
| arb_en | input | 1 | Arbitrate enable from mode register |
| tgt_mode | input | 1 | Target mode from mode register |
| out_data | input | 8 | ID byte placed on the data bus |
| irq_ack | input | 1 | Clears the interrupt latch |
| bsy_in | input | 1 | Raw BSY line level, 1 = asserted |
| sel_in | input | 1 | Raw SEL line level, 1 = asserted |
| rst_drv | output | 1 | Drive bus RST |
| bsy_drv | output | 1 | Drive bus BSY |
| sel_drv | output | 1 | Drive bus SEL |
| ack_drv | output | 1 | Drive bus ACK |
| atn_drv | output | 1 | Drive bus ATN |
| db_drv_en | output | 1 | Enable data-bus drivers |
| db_out | output | 8 | Data-bus byte |
| irq | output | 1 | Interrupt request latch |
| soft_rst | output | 1 | One-cycle internal reset pulse |

## Verification
The checker watches the relations that hold on every cycle:
- target mode masking ACK,
- the clearing and interrupt effect of a bus-reset write,
- release of RST on a write of 0,
- the interrupt latch holding until acknowledged,
- arbitration flags dropping once `arb_en` is low,
- a lost arbitration never driving BSY on its own account.

Only the bench's scenarios can show the exact count of idle cycles before arbitration starts. The same holds for the latency from a foreign SEL to the lost flag, and the read-back of each written pattern.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;
  localparam int REG_W = 8;
  localparam int B_RST = 7;
  localparam int B_AIP = 6;
  localparam int B_LA  = 5;
  localparam int B_ACK = 4;
  localparam int B_BSY = 3;
  localparam int B_SEL = 2;
  localparam int B_ATN = 1;
  localparam int B_DBE = 0;
  localparam int CTL_W = B_ACK + 1;

  typedef enum logic [1:0] {
    ARB_IDLE,
    ARB_DRIVE,
    ARB_LOST
  } arb_state_e;
endpackage

// File: rtl/scsi_bus_sync.sv
module scsi_bus_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] shift_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= {shift_q[STAGES-2:0], raw[i]};
    end
    assign synced[i] = shift_q[STAGES-1];
  end
endmodule

// File: rtl/scsi_free_det.sv
module scsi_free_det #(
  parameter int FREE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bsy_s,
  input  logic sel_s,
  output logic bus_free
);
  localparam int CW = $clog2(FREE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FREE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          idle;

  assign idle = !bsy_s && !sel_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr || !idle)       cnt_q <= '0;
    else if (cnt_q != LIMIT)     cnt_q <= cnt_q + 1'b1;
  end

  assign bus_free = (cnt_q == LIMIT);
endmodule

// File: rtl/scsi_arb_fsm.sv
module scsi_arb_fsm
  import scsi_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arb_en,
  input  logic bus_free,
  input  logic sel_s,
  input  logic own_sel,
  output logic aip,
  output logic lost,
  output logic arb_drive
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clr || !arb_en) begin
      state_d = ARB_IDLE;
    end else begin
      unique case (state_q)
        ARB_IDLE:  if (bus_free)          state_d = ARB_DRIVE;
        ARB_DRIVE: if (sel_s && !own_sel) state_d = ARB_LOST;
        ARB_LOST:                         state_d = ARB_LOST;
        default:                          state_d = ARB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign aip       = (state_q != ARB_IDLE);
  assign lost      = (state_q == ARB_LOST);
  assign arb_drive = (state_q == ARB_DRIVE);
endmodule

// File: rtl/scsi_init_ctl.sv
module scsi_init_ctl
  import scsi_ctl_pkg::*;
#(
  parameter int FREE_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             arb_en,
  input  logic             tgt_mode,
  input  logic [REG_W-1:0] out_data,
  input  logic             irq_ack,
  input  logic             bsy_in,
  input  logic             sel_in,
  output logic             rst_drv,
  output logic             bsy_drv,
  output logic             sel_drv,
  output logic             ack_drv,
  output logic             atn_drv,
  output logic             db_drv_en,
  output logic [REG_W-1:0] db_out,
  output logic             irq,
  output logic             soft_rst
);
  logic             rst_q, irq_q, soft_q;
  logic [CTL_W-1:0] ctl_q;
  logic             wr_rst, clr;
  logic [1:0]       bus_s;
  logic             bus_free, aip, lost, arb_drive;
  logic             ro_unused;

  assign wr_rst    = wr_en && wr_data[B_RST];
  assign clr       = rst_q || wr_rst;
  assign ro_unused = ^wr_data[B_AIP:B_LA];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      ctl_q  <= '0;
      irq_q  <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      if (wr_en) begin
        rst_q <= wr_data[B_RST];
        ctl_q <= wr_data[B_RST] ? '0 : wr_data[CTL_W-1:0];
      end
      soft_q <= wr_rst;
      if (wr_rst)       irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;
    end
  end

  scsi_bus_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    ({sel_in, bsy_in}),
    .synced (bus_s)
  );

  scsi_free_det #(.FREE_CYCLES(FREE_CYCLES)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .bsy_s    (bus_s[0]),
    .sel_s    (bus_s[1]),
    .bus_free (bus_free)
  );

  scsi_arb_fsm u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .arb_en    (arb_en),
    .bus_free  (bus_free),
    .sel_s     (bus_s[1]),
    .own_sel   (ctl_q[B_SEL]),
    .aip       (aip),
    .lost      (lost),
    .arb_drive (arb_drive)
  );

  assign rd_data   = {rst_q, aip, lost, ctl_q};
  assign rst_drv   = rst_q;
  assign bsy_drv   = ctl_q[B_BSY] || arb_drive;
  assign sel_drv   = ctl_q[B_SEL];
  assign ack_drv   = ctl_q[B_ACK] && !tgt_mode;
  assign atn_drv   = ctl_q[B_ATN];
  assign db_drv_en = ctl_q[B_DBE] || arb_drive;
  assign db_out    = out_data;
  assign irq       = irq_q;
  assign soft_rst  = soft_q;
endmodule

// File: rtl/scsi_init_ctl_chk.sv
module scsi_init_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       arb_en,
  input logic       tgt_mode,
  input logic       irq_ack,
  input logic       rst_drv,
  input logic       bsy_drv,
  input logic       ack_drv,
  input logic       irq,
  input logic       soft_rst
);
  AST_TGT_MASKS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_mode |-> !ack_drv); // R6
  AST_RST_WRITE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7]) |=> (rst_drv && irq && soft_rst && rd_data[6:0] == 7'd0)); // R3
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7]) |=> !rst_drv); // R2
  AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R4
  AST_ARB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> (rd_data[6:5] == 2'b00)); // R10
  AST_LOST_NO_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5] && !rd_data[3]) |-> !bsy_drv); // R9
  AST_LOST_KEEPS_AIP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] |-> rd_data[6]); // R9
endmodule

bind scsi_init_ctl scsi_init_ctl_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .arb_en   (arb_en),
  .tgt_mode (tgt_mode),
  .irq_ack  (irq_ack),
  .rst_drv  (rst_drv),
  .bsy_drv  (bsy_drv),
  .ack_drv  (ack_drv),
  .irq      (irq),
  .soft_rst (soft_rst)
);

// File: tb/test_scsi_init_ctl.sv
`timescale 1ns/1ps
module test_scsi_init_ctl;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, arb_en = 0, tgt_mode = 0, irq_ack = 0;
  logic       bsy_in = 0, sel_in = 0;
  logic [7:0] wr_data = 0, out_data = 8'h40;
  logic [7:0] rd_data, db_out;
  logic       rst_drv, bsy_drv, sel_drv, ack_drv, atn_drv, db_drv_en, irq, soft_rst;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  scsi_init_ctl #(.FREE_CYCLES(4)) i_scsi_init_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .arb_en(arb_en), .tgt_mode(tgt_mode), .out_data(out_data), .irq_ack(irq_ack),
    .bsy_in(bsy_in), .sel_in(sel_in), .rst_drv(rst_drv), .bsy_drv(bsy_drv),
    .sel_drv(sel_drv), .ack_drv(ack_drv), .atn_drv(atn_drv), .db_drv_en(db_drv_en),
    .db_out(db_out), .irq(irq), .soft_rst(soft_rst)
  );

  // {tgt_mode, write byte, expected read, expected {rst,bsy,sel,ack,atn,dbe}}
  localparam logic [22:0] VEC [7] = '{
    {1'b0, 8'h1F, 8'h1F, 6'b011111},
    {1'b1, 8'h1F, 8'h1F, 6'b011011},
    {1'b0, 8'h6A, 8'h0A, 6'b010010},
    {1'b0, 8'h14, 8'h14, 6'b001100},
    {1'b0, 8'h9F, 8'h80, 6'b100000},
    {1'b0, 8'h83, 8'h80, 6'b100000},
    {1'b0, 8'h00, 8'h00, 6'b000000}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R5";
      1: return "R6";
      2: return "R11";
      3: return "R5";
      4: return "R3";
      5: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic [5:0] outs();
    return {rst_drv, bsy_drv, sel_drv, ack_drv, atn_drv, db_drv_en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd", rd_data, 0);
    chk("R1 outs", outs(), 0);
    chk("R1 irq", {irq, soft_rst}, 0);

    for (int i = 0; i < 7; i++) begin
      @(negedge clk); tgt_mode = VEC[i][22];
      do_write(VEC[i][21:14]);
      chk({vtag(i), " rd"}, rd_data, VEC[i][13:6]);
      chk({vtag(i), " outs"}, outs(), VEC[i][5:0]);
    end
    tgt_mode = 0;

    chk("R4 irq held", irq, 1);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R4 irq cleared", irq, 0);

    @(negedge clk); wr_en = 1; wr_data = 8'h80;
    @(negedge clk); wr_en = 0;
    chk("R3 soft pulse", soft_rst, 1);
    chk("R4 irq set", irq, 1);
    @(negedge clk);
    chk("R3 soft pulse end", soft_rst, 0);
    do_write(8'h00);
    chk("R2 rst released", rst_drv, 0);
    chk("R4 irq survives", irq, 1);
    repeat (10) @(negedge clk);

    arb_en = 1;
    @(negedge clk);
    chk("R8 aip", rd_data[6:5], 2'b10);
    chk("R8 drive", {bsy_drv, db_drv_en}, 2'b11);
    chk("R8 data", db_out, 8'h40);

    do_write(8'h80);
    chk("R3 arb wiped", rd_data, 8'h80);
    do_write(8'h00);

    arb_en = 0; bsy_in = 1;
    repeat (4) @(negedge clk);
    bsy_in = 0; arb_en = 1;
    repeat (6) @(negedge clk);
    chk("R7 not yet free", rd_data[6], 0);
    @(negedge clk);
    chk("R7 free after window", rd_data[6], 1);

    sel_in = 1;
    repeat (3) @(negedge clk);
    chk("R9 lost flags", rd_data[6:5], 2'b11);
    chk("R9 released", {bsy_drv, db_drv_en}, 2'b00);

    arb_en = 0;
    @(negedge clk);
    chk("R10 flags cleared", rd_data[6:5], 2'b00);
    sel_in = 0;
    repeat (2) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule